// File: doc/BRIEF.md
# I2C Target with a 16-bit Register Port

This block lets an I2C bus master read and write a bank of 16-bit registers that sit in a separate register file. It runs on a fast system clock. Both bus lines are passed through a synchronizer and oversampled. The block finds START, repeated START and STOP conditions. It compares the 7-bit device address against a five-bit prefix whose two low bits are don't-care, and it answers each byte with an acknowledge by pulling SDA low through an open-drain enable.

In a write transaction, the first data byte sets an internal register pointer. Every later pair of bytes, high byte first, becomes one register write, and the pointer then steps forward. In a read transaction, the block returns the pointed register high byte first and then low byte. It steps the pointer and keeps sending until the master answers with NACK.

The pointer never wraps. Once it moves past the last register, further write pairs are acknowledged but thrown away, and reads keep returning the last register. The pointer keeps its value across STOP and repeated START, so a short write that only sets the pointer prepares the read that follows.

The register file port has no back-pressure. The write strobe lasts one cycle and must be taken in that cycle. Read data must follow `reg_rd_addr` combinationally in the same cycle.

Top module: `i2c16_reg_target`

## Requirements
- R1: A falling SDA while SCL is high starts a transaction, even without a prior STOP. A rising SDA while SCL is high ends it and releases SDA.
- R2: An address byte whose upper five bits are 01011 is acknowledged whatever its two low bits. Any other address gets no ACK, and the target leaves SDA released and writes nothing until the next START.
- R3: In a write (R/W bit = 0), the first data byte loads the pointer. A loaded value above 64 is clamped to 64 (past the end), so writes are dropped and reads return register 0x3F.
- R4: Each following byte pair produces exactly one single-cycle write strobe with data {first byte, second byte}. The strobe is issued only after the second byte has been acknowledged.
- R5: The target drives an ACK after every byte of a matched write, including between the two halves of a pair. It changes SDA only while SCL is low, except for release at START or STOP.
- R6: The pointer rises by one after each completed pair and stops at 64. Pairs that arrive when the pointer is 64 are acknowledged but produce no strobe, and register 0x00 is never reached by wrapping.
- R7: A write that ends after an unpaired byte writes nothing for that byte. A later transaction starts pairing afresh.
- R8: In a read (R/W bit = 1), the target sends the high byte then the low byte of the pointed register, MSB first. It steps the pointer after the low byte and continues while the master sends ACK. After a NACK it releases SDA.
- R9: A read that continues past register 0x3F keeps returning register 0x3F.
- R10: The pointer survives STOP and repeated START, so the next read starts at the value set by the last write.
- R11: After reset, SDA is released, no write strobe occurs and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 6 | Register written by the strobe |
| reg_wr_data | output | 16 | Data for the strobe |
| reg_rd_addr | output | 6 | Register currently selected for reading |
| reg_rd_data | input | 16 | Contents of `reg_rd_addr`, same cycle |

## Verification
The bench builds the block with its defaults: a 64-entry bank, the 01011 address prefix and a two-stage synchronizer. With only 64 registers, a transaction that starts at 0x3E runs past the end within a few words, so saturation of the pointer, dropped writes and repeated reads of 0x3F are all reached cheaply. Stepping through all four values of the don't-care address bits, and using a pointer value above 64, covers the address decode and the clamp on the loaded pointer.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c16_line_sync.sv
module i2c16_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c16_ptr.sv
module i2c16_ptr #(
  parameter int NUM_REGS = 64,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    load_val,
  input  logic          inc,
  output logic [7:0]    ptr,
  output logic          in_range,
  output logic [AW-1:0] rd_addr
);
  localparam logic [7:0] PTR_END = 8'(NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= (load_val > PTR_END) ? PTR_END : load_val;
    end else if (inc && ptr < PTR_END) begin
      ptr <= ptr + 8'd1;
    end
  end

  assign in_range = (ptr < PTR_END);
  assign rd_addr  = in_range ? ptr[AW-1:0] : AW'(NUM_REGS - 1);
endmodule

// File: rtl/i2c16_reg_target.sv
module i2c16_reg_target
  import i2c16_pkg::*;
#(
  parameter logic [4:0] DEV_HI      = 5'b01011,
  parameter int         NUM_REGS    = 64,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_wr_en,
  output logic [AW-1:0] reg_wr_addr,
  output logic [15:0]   reg_wr_data,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [15:0]   reg_rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr_cur;
  logic ptr_in_range;
  logic [AW-1:0] ptr_rd_addr;

  tgt_state_t state_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q, hi_q, lo_q, tx_q, ptr_val_q;
  logic rw_q, ack_ph_q, first_q, hi_valid_q, lo_half_q, mack_q;
  logic sda_oe_q, wr_en_q, ptr_load_q, ptr_inc_q;
  logic [AW-1:0] wr_addr_q;
  logic [15:0] wr_data_q;

  i2c16_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c16_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load_q), .load_val(ptr_val_q),
    .inc(ptr_inc_q), .ptr(ptr_cur), .in_range(ptr_in_range),
    .rd_addr(ptr_rd_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      tx_q       <= '0;
      ptr_val_q  <= '0;
      rw_q       <= 1'b0;
      ack_ph_q   <= 1'b0;
      first_q    <= 1'b0;
      hi_valid_q <= 1'b0;
      lo_half_q  <= 1'b0;
      mack_q     <= 1'b1;
      sda_oe_q   <= 1'b0;
      wr_en_q    <= 1'b0;
      ptr_load_q <= 1'b0;
      ptr_inc_q  <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q    <= 1'b0;
      ptr_load_q <= 1'b0;
      ptr_inc_q  <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        sda_oe_q   <= 1'b0;
        ack_ph_q   <= 1'b0;
        hi_valid_q <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_oe_q   <= 1'b0;
        ack_ph_q   <= 1'b0;
        hi_valid_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              rw_q    <= sda_s;
              state_q <= (sh_q[6:2] == DEV_HI) ? ST_ADDR_ACK : ST_SKIP;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!ack_ph_q) begin
              sda_oe_q <= 1'b1;
              ack_ph_q <= 1'b1;
            end else begin
              ack_ph_q <= 1'b0;
              cnt_q    <= '0;
              if (rw_q) begin
                state_q   <= ST_RD;
                tx_q      <= reg_rd_data[15:8];
                lo_q      <= reg_rd_data[7:0];
                sda_oe_q  <= ~reg_rd_data[15];
                lo_half_q <= 1'b0;
              end else begin
                state_q  <= ST_WR;
                sda_oe_q <= 1'b0;
                first_q  <= 1'b1;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) state_q <= ST_WR_ACK;
          end
          ST_WR_ACK: if (scl_fall) begin
            if (!ack_ph_q) begin
              sda_oe_q <= 1'b1;
              ack_ph_q <= 1'b1;
            end else begin
              sda_oe_q <= 1'b0;
              ack_ph_q <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_WR;
              if (first_q) begin
                first_q    <= 1'b0;
                ptr_load_q <= 1'b1;
                ptr_val_q  <= sh_q;
              end else if (!hi_valid_q) begin
                hi_q       <= sh_q;
                hi_valid_q <= 1'b1;
              end else begin
                hi_valid_q <= 1'b0;
                ptr_inc_q  <= 1'b1;
                if (ptr_in_range) begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_rd_addr;
                  wr_data_q <= {hi_q, sh_q};
                end
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              if (cnt_q == 3'd7) begin
                state_q <= ST_RD_ACK;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 3'd1;
              end
            end else if (scl_fall) begin
              sda_oe_q <= ~tx_q[3'd7 - cnt_q];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise && ack_ph_q) begin
              mack_q <= sda_s;
            end else if (scl_fall) begin
              if (!ack_ph_q) begin
                sda_oe_q  <= 1'b0;
                ack_ph_q  <= 1'b1;
                ptr_inc_q <= lo_half_q;
              end else begin
                ack_ph_q <= 1'b0;
                if (mack_q) begin
                  state_q <= ST_SKIP;
                end else begin
                  state_q <= ST_RD;
                  if (lo_half_q) begin
                    tx_q      <= reg_rd_data[15:8];
                    lo_q      <= reg_rd_data[7:0];
                    sda_oe_q  <= ~reg_rd_data[15];
                    lo_half_q <= 1'b0;
                  end else begin
                    tx_q      <= lo_q;
                    sda_oe_q  <= ~lo_q[7];
                    lo_half_q <= 1'b1;
                  end
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe      = sda_oe_q;
  assign reg_wr_en   = wr_en_q;
  assign reg_wr_addr = wr_addr_q;
  assign reg_wr_data = wr_data_q;
  assign reg_rd_addr = ptr_rd_addr;
endmodule

// File: rtl/i2c16_reg_target_chk.sv
module i2c16_reg_target_chk #(
  parameter int NUM_REGS = 64,
  localparam int AW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_wr_addr,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic [7:0]    ptr,
  input logic          ptr_load
);
  localparam logic [7:0] PTR_END = 8'(NUM_REGS);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe) else $error("stop did not release SDA"); // R1

  AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s))
    else $error("SDA changed while SCL high"); // R5

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en) else $error("write strobe longer than one cycle"); // R4

  AST_WR_ONLY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($past(ptr) < PTR_END && $past(ptr[AW-1:0]) == reg_wr_addr))
    else $error("write outside pointer range"); // R6

  AST_PTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == PTR_END && !$past(ptr_load)) |-> ptr == PTR_END)
    else $error("pointer left its end value"); // R6

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_END) else $error("pointer beyond clamp"); // R3
endmodule

bind i2c16_reg_target i2c16_reg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
  .reg_wr_addr(reg_wr_addr), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .ptr(ptr_cur), .ptr_load(ptr_load_q)
);

// File: tb/i2c16_reg_target_tb.sv
`timescale 1ns/100ps
module i2c16_reg_target_tb;
  localparam int NREG = 64;
  localparam time QT = 50ns;
  localparam logic [4:0] DEV = 5'b01011;
  // {pointer, data}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'hA55A}, {8'h3F, 16'h0001}, {8'h15, 16'hFFFF},
    {8'h20, 16'h8000}, {8'h07, 16'h1234}, {8'h2A, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe, reg_wr_en;
  logic [5:0] reg_wr_addr, reg_rd_addr;
  logic [15:0] reg_wr_data, reg_rd_data;
  logic [15:0] rf [NREG];
  logic [15:0] rd_buf [4];
  int wr_cnt = 0, n_chk = 0, n_bad = 0, base;
  logic ack_or, last_ack;

  always #2.5 clk = ~clk;
  assign sda_line    = sda_m & ~sda_oe;
  assign reg_rd_data = rf[reg_rd_addr];

  always @(posedge clk)
    if (reg_wr_en) begin
      rf[reg_wr_addr] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
    end

  i2c16_reg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QT; scl_m = 1'b1; #QT; sda_m = 1'b0; #QT; scl_m = 1'b0; #QT;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; #QT; scl_m = 1'b1; #QT; sda_m = 1'b1; #QT;
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; #QT; scl_m = 1'b1; #(2*QT); scl_m = 1'b0; #QT;
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; #QT; scl_m = 1'b1; #QT; b = sda_line; #QT; scl_m = 1'b0; #QT;
  endtask
  task automatic send_byte(input logic [7:0] b);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    last_ack = a;
    ack_or |= a;
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic t;
    for (int i = 7; i >= 0; i--) begin get_bit(t); b[i] = t; end
    put_bit(nack);
  endtask
  task automatic read_words(input int n);
    logic [7:0] h, l;
    for (int k = 0; k < n; k++) begin
      recv_byte(h, 1'b0);
      recv_byte(l, k == n - 1);
      rd_buf[k] = {h, l};
    end
  endtask
  task automatic write_pair(input logic [15:0] d);
    send_byte(d[15:8]); send_byte(d[7:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = 16'h0;
    #100ns; rst_n = 1'b1; #100ns;
    // R11: reset state at the ports
    chk(sda_oe == 1'b0, "R11 sda released", 32'(sda_oe), 0);
    chk(reg_rd_addr == 6'd0, "R11 pointer zero", 32'(reg_rd_addr), 0);
    chk(wr_cnt == 0, "R11 no strobe", wr_cnt, 0);

    // table walk: write one register, read it back with repeated START
    for (int k = 0; k < 6; k++) begin
      logic [7:0] p;
      logic [15:0] d;
      p = VEC[k][23:16];
      d = VEC[k][15:0];
      ack_or = 1'b0;
      bus_start(); send_byte({DEV, 2'(k), 1'b0}); send_byte(p); write_pair(d); bus_stop();
      chk(ack_or == 1'b0, "R5 write acks", 32'(ack_or), 0);
      chk(rf[p[5:0]] == d, "R4 write data", rf[p[5:0]], d);
      ack_or = 1'b0;
      bus_start(); send_byte({DEV, 2'(k + 1), 1'b0}); send_byte(p);
      bus_start(); send_byte({DEV, 2'(3 - k), 1'b1}); read_words(1); bus_stop();
      chk(ack_or == 1'b0, "R2 don't-care bits acked", 32'(ack_or), 0);
      chk(rd_buf[0] == d, "R8 readback", rd_buf[0], d);
    end

    // R2: address mismatch is ignored until next START
    base = wr_cnt; ack_or = 1'b0;
    bus_start(); send_byte({5'b01010, 2'b11, 1'b0});
    chk(last_ack == 1'b1, "R2 mismatch not acked", 32'(last_ack), 1);
    send_byte(8'h05); send_byte(8'h11); send_byte(8'h22); bus_stop();
    chk(last_ack == 1'b1, "R2 ignored bytes not acked", 32'(last_ack), 1);
    chk(wr_cnt == base, "R2 no write after mismatch", wr_cnt, base);

    // R6/R5: burst write with auto-increment
    base = wr_cnt; ack_or = 1'b0;
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h10);
    write_pair(16'h1111); write_pair(16'h2222); write_pair(16'h3333); bus_stop();
    chk(ack_or == 1'b0, "R5 ack every byte incl. halves", 32'(ack_or), 0);
    chk(wr_cnt == base + 3, "R6 three strobes", wr_cnt, base + 3);
    chk(rf[6'h11] == 16'h2222, "R6 second pair to next reg", rf[6'h11], 16'h2222);
    chk(rf[6'h12] == 16'h3333, "R6 third pair", rf[6'h12], 16'h3333);

    // R1/R10: pointer kept across repeated START
    bus_start(); send_byte({DEV, 2'b01, 1'b0}); send_byte(8'h11);
    bus_start(); send_byte({DEV, 2'b01, 1'b1}); read_words(2); bus_stop();
    chk(rd_buf[0] == 16'h2222, "R10 read after Sr", rd_buf[0], 16'h2222);
    chk(rd_buf[1] == 16'h3333, "R8 pointer steps on read", rd_buf[1], 16'h3333);
    chk(sda_oe == 1'b0, "R8 released after NACK", 32'(sda_oe), 0);
    // R10: pointer kept across STOP
    bus_start(); send_byte({DEV, 2'b10, 1'b0}); send_byte(8'h10); bus_stop();
    bus_start(); send_byte({DEV, 2'b10, 1'b1}); read_words(1); bus_stop();
    chk(rd_buf[0] == 16'h1111, "R10 read after STOP", rd_buf[0], 16'h1111);

    // R7: unpaired byte dropped, next transaction pairs afresh
    base = wr_cnt;
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h30);
    write_pair(16'h4444); send_byte(8'hEE); bus_stop();
    chk(wr_cnt == base + 1, "R7 odd byte no strobe", wr_cnt, base + 1);
    chk(rf[6'h31] == 16'h0000, "R7 reg untouched", rf[6'h31], 0);
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h31);
    write_pair(16'h2233); bus_stop();
    chk(rf[6'h31] == 16'h2233, "R7 fresh pairing", rf[6'h31], 16'h2233);
    chk(wr_cnt == base + 2, "R7 one strobe", wr_cnt, base + 2);

    // R6: writes past the end dropped, no wrap to 0x00
    base = wr_cnt; ack_or = 1'b0;
    bus_start(); send_byte({DEV, 2'b11, 1'b0}); send_byte(8'h3F);
    write_pair(16'hBEEF); write_pair(16'hDEAD); write_pair(16'hF00D); bus_stop();
    chk(wr_cnt == base + 1, "R6 past-end dropped", wr_cnt, base + 1);
    chk(rf[6'h3F] == 16'hBEEF, "R6 last reg written once", rf[6'h3F], 16'hBEEF);
    chk(rf[6'h00] == 16'hA55A, "R6 no wrap", rf[6'h00], 16'hA55A);
    chk(ack_or == 1'b0, "R6 dropped bytes still acked", 32'(ack_or), 0);

    // R9: read repeats last register
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h3E);
    bus_start(); send_byte({DEV, 2'b00, 1'b1}); read_words(3); bus_stop();
    chk(rd_buf[0] == rf[6'h3E], "R9 first word", rd_buf[0], rf[6'h3E]);
    chk(rd_buf[1] == 16'hBEEF, "R9 last reg", rd_buf[1], 16'hBEEF);
    chk(rd_buf[2] == 16'hBEEF, "R9 repeated last reg", rd_buf[2], 16'hBEEF);

    // R3: loaded pointer above range is clamped
    base = wr_cnt;
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h80);
    write_pair(16'h7777); bus_stop();
    chk(wr_cnt == base, "R3 clamped pointer drops write", wr_cnt, base);
    bus_start(); send_byte({DEV, 2'b00, 1'b0}); send_byte(8'h80);
    bus_start(); send_byte({DEV, 2'b00, 1'b1}); read_words(1); bus_stop();
    chk(rd_buf[0] == 16'hBEEF, "R3 clamped pointer reads last", rd_buf[0], 16'hBEEF);

    #200ns;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule